// File: doc/BRIEF.md
# Sub-Vector Pack/Unpack Index Generator

This block produces the element offsets for a move-style operation that runs over a vector of VL elements, each element made of SUBVL sub-elements (SUBVL from 1 to 4). Every output beat carries one source offset and one destination offset. Two independent walkers produce them, one for each side, and both advance on the same beat. Each walker follows one of two loop nestings. In element-major order, the element counter is the outer loop and the sub-element counter is the inner loop. In subvector-major order, the sub-element counter is the outer loop. In subvector-major order the walker visits sub-element 0 of every element first, then sub-element 1, and so on. This gathers ("packs") the sub-elements, or scatters ("unpacks") them, when the other side walks in element-major order.

A one-cycle `start` pulse, given while the block is idle, captures the vector length, the sub-vector length and the two ordering enables. The offset pairs then leave on a valid/ready stream. A beat is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low the current beat stays on the outputs unchanged and neither walker moves. `out_valid` never drops before its beat has been transferred. The final beat of an operation is flagged with `out_last`, and the block goes idle once that beat is transferred.

Top module: `subvec_pack_idx_gen`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a `start` pulse is accepted.
- R2: A `start` pulse is accepted only while `out_valid` is low. When `vl` is 1 or more, `out_valid` is high in the cycle after the accepting edge.
- R3: A walker whose enable is 0 follows element-major order. The element counter i is the outer loop and the sub-element counter j is the inner loop, and the offset is i*SUBVL+j. The resulting sequence is 0, 1, 2, and so on.
- R4: A walker whose enable is 1 follows subvector-major order. Counter j is the outer loop (0 to SUBVL-1) and counter i is the inner loop (0 to VL-1), and the offset is again i*SUBVL+j.
- R5: `pack_en` selects the order of the source walker (`src_idx`) and `unpack_en` selects the order of the destination walker (`dst_idx`). The two enables act independently, and setting both at once is legal.
- R6: Every operation transfers exactly VL*SUBVL beats. `out_last` is high on the final beat only, and `out_valid` is low in the cycle after that beat is transferred.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high with `src_idx` and `dst_idx` unchanged.
- R8: When both enables are 0, `src_idx` equals `dst_idx` on every beat.
- R9: A `start` pulse given while `out_valid` is high is ignored, and the current operation runs on unchanged. A `start` pulse with `vl` equal to 0 produces no beats.
- R10: The sub-vector length is coded as `subvl_m1`, where SUBVL = `subvl_m1`+1. A `vl` value above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted while idle) |
| vl | input | $clog2(MAX_VL+1) | Vector length in elements |
| subvl_m1 | input | 2 | Sub-vector length minus one |
| pack_en | input | 1 | Source walker uses subvector-major order |
| unpack_en | input | 1 | Destination walker uses subvector-major order |
| out_valid | output | 1 | Offset pair is present |
| out_ready | input | 1 | Consumer accepts the pair |
| src_idx | output | $clog2(MAX_VL*4) | Source element offset |
| dst_idx | output | $clog2(MAX_VL*4) | Destination element offset |
| out_last | output | 1 | Final pair of the operation |

## Verification
The hardest situation to reach is a start pulse arriving in the middle of a long operation that is under back-pressure. Only there can a careless design reload its captured configuration or reset its walkers. The stimulus starts a 12-beat packing operation with a stalling consumer, then pulses `start` with a different length and ordering a few cycles later. The scoreboard still expects the original sequence. Ready stalls come from a shift-register pattern, so stalls also fall on the last beat and on the wrap points of each walker's inner loop.

// File: rtl/subvec_pkg.sv
package subvec_pkg;
  // Sub-vector length is coded in two bits: SUBVL = code + 1, range 1..4.
  localparam int SV_W      = 2;
  localparam int MAX_SUBVL = 1 << SV_W;

  typedef logic [SV_W-1:0] sv_code_t;
endpackage

// File: rtl/subvec_walker.sv
module subvec_walker
  import subvec_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int CW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int IDXW  = $clog2(MAX_VL * MAX_SUBVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            outer_sv,
  input  logic [CW-1:0]   vl_m1,
  input  sv_code_t        sv_m1,
  output logic [IDXW-1:0] offset,
  output logic            at_end
);
  logic [CW-1:0] elem_q;
  sv_code_t      sub_q;
  logic          elem_wrap;
  logic          sub_wrap;

  assign elem_wrap = (elem_q == vl_m1);
  assign sub_wrap  = (sub_q == sv_m1);
  assign at_end    = elem_wrap && sub_wrap;

  // The offset is element*SUBVL + sub-element; only the loop nesting differs.
  assign offset = IDXW'(elem_q) * IDXW'({1'b0, sv_m1} + 3'd1) + IDXW'(sub_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else if (load) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else if (step) begin
      if (outer_sv) begin
        if (elem_wrap) begin
          elem_q <= '0;
          sub_q  <= sub_q + 1'b1;
        end else begin
          elem_q <= elem_q + 1'b1;
        end
      end else begin
        if (sub_wrap) begin
          sub_q  <= '0;
          elem_q <= elem_q + 1'b1;
        end else begin
          sub_q  <= sub_q + 1'b1;
        end
      end
    end
  end

  // Counters never pass the captured bounds while beats are transferred (R6).
  assert_walk_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (elem_q <= vl_m1) && (sub_q <= sv_m1));
endmodule

// File: rtl/subvec_seq_ctrl.sv
module subvec_seq_ctrl
  import subvec_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int CW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  sv_code_t       subvl_m1,
  input  logic           pack_en,
  input  logic           unpack_en,
  input  logic           out_ready,
  input  logic           walk_end,
  output logic           run,
  output logic           load,
  output logic           step,
  output logic [CW-1:0]  vl_m1_q,
  output sv_code_t       sv_m1_q,
  output logic           pack_q,
  output logic           unpack_q
);
  logic [VLW-1:0] vl_eff;

  assign vl_eff = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
  assign load   = start && !run;
  assign step   = run && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      vl_m1_q  <= '0;
      sv_m1_q  <= '0;
      pack_q   <= 1'b0;
      unpack_q <= 1'b0;
    end else if (load) begin
      run      <= (vl != '0);
      vl_m1_q  <= CW'(vl_eff - 1'b1);
      sv_m1_q  <= subvl_m1;
      pack_q   <= pack_en;
      unpack_q <= unpack_en;
    end else if (step && walk_end) begin
      run <= 1'b0;
    end
  end

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !out_ready) |=> run);

  assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && walk_end) |=> !run);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start) |=> ($stable(pack_q) && $stable(unpack_q) &&
                        $stable(vl_m1_q) && $stable(sv_m1_q)));
endmodule

// File: rtl/subvec_pack_idx_gen.sv
module subvec_pack_idx_gen
  import subvec_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int CW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int IDXW  = $clog2(MAX_VL * MAX_SUBVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [1:0]      subvl_m1,
  input  logic            pack_en,
  input  logic            unpack_en,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IDXW-1:0] src_idx,
  output logic [IDXW-1:0] dst_idx,
  output logic            out_last
);
  logic          run;
  logic          load;
  logic          step;
  logic [CW-1:0] vl_m1_q;
  sv_code_t      sv_m1_q;
  logic          pack_q;
  logic          unpack_q;
  logic          outer_sel [2];
  logic [IDXW-1:0] offs    [2];
  logic          ends      [2];

  subvec_seq_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl        (vl),
    .subvl_m1  (subvl_m1),
    .pack_en   (pack_en),
    .unpack_en (unpack_en),
    .out_ready (out_ready),
    .walk_end  (ends[0]),
    .run       (run),
    .load      (load),
    .step      (step),
    .vl_m1_q   (vl_m1_q),
    .sv_m1_q   (sv_m1_q),
    .pack_q    (pack_q),
    .unpack_q  (unpack_q)
  );

  assign outer_sel[0] = pack_q;
  assign outer_sel[1] = unpack_q;

  // Walker 0 drives the source side, walker 1 the destination side.
  for (genvar w = 0; w < 2; w++) begin : g_walk
    subvec_walker #(.MAX_VL(MAX_VL)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .outer_sv (outer_sel[w]),
      .vl_m1    (vl_m1_q),
      .sv_m1    (sv_m1_q),
      .offset   (offs[w]),
      .at_end   (ends[w])
    );
  end

  assign out_valid = run;
  assign src_idx   = offs[0];
  assign dst_idx   = offs[1];
  assign out_last  = run && ends[0];

  assert_walkers_end_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ends[0] == ends[1]));

  assert_stall_keeps_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(src_idx) && $stable(dst_idx)));

  assert_plain_copy_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pack_q && !unpack_q) |-> (src_idx == dst_idx));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !load) |=> !out_valid);
endmodule

// File: tb/subvec_pack_idx_gen_test.sv
module subvec_pack_idx_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL     = 16;
  localparam int VLW        = $clog2(MAX_VL + 1);
  localparam int IDXW       = $clog2(MAX_VL * 4);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [VLW-1:0]  vl = '0;
  logic [1:0]      subvl_m1 = '0;
  logic            pack_en = 1'b0;
  logic            unpack_en = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [IDXW-1:0] src_idx;
  logic [IDXW-1:0] dst_idx;
  logic            out_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   rdy_rand = 1'b0;
  bit   cur_plain = 1'b0;
  bit   prev_hold = 1'b0;
  logic [IDXW-1:0] prev_src = '0;
  logic [IDXW-1:0] prev_dst = '0;
  logic [2*IDXW:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  subvec_pack_idx_gen #(.MAX_VL(MAX_VL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl_m1(subvl_m1),
    .pack_en(pack_en), .unpack_en(unpack_en), .out_valid(out_valid),
    .out_ready(out_ready), .src_idx(src_idx), .dst_idx(dst_idx), .out_last(out_last)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int idx_at(int k, bit outer, int nv, int ns);
    if (!outer) return k;
    return (k % nv) * ns + (k / nv);
  endfunction

  // Monitor: update ready first, then judge the beat that the next edge transfers.
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = rdy_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (prev_hold) begin
        check(out_valid == 1'b1, "R7 valid held in stall", int'(out_valid), 1);
        check(src_idx == prev_src && dst_idx == prev_dst, "R7 pair held in stall",
              int'(src_idx), int'(prev_src));
      end
      prev_hold = out_valid && !out_ready;
      prev_src  = src_idx;
      prev_dst  = dst_idx;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 R9 beat with no expected item", int'(src_idx), -1);
        end else begin
          logic [2*IDXW:0] e;
          e = exp_q.pop_front();
          check(src_idx == e[2*IDXW:IDXW+1], "R3 R4 R5 src_idx",
                int'(src_idx), int'(e[2*IDXW:IDXW+1]));
          check(dst_idx == e[IDXW:1], "R3 R4 R5 dst_idx",
                int'(dst_idx), int'(e[IDXW:1]));
          check(out_last == e[0], "R6 out_last", int'(out_last), int'(e[0]));
          if (cur_plain) check(src_idx == dst_idx, "R8 src equals dst",
                               int'(src_idx), int'(dst_idx));
        end
      end
    end
  end

  task automatic wait_done();
    while (exp_q.size() != 0 || out_valid) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R6 idle after final beat", int'(out_valid), 0);
  endtask

  // Driver: push the expected pairs, then pulse start.
  task automatic run_op(input int v, input int svm1, input bit pk, input bit upk,
                        input bit rr, input bit poke_busy);
    int nv;
    int ns;
    nv = (v > MAX_VL) ? MAX_VL : v;
    ns = svm1 + 1;
    @(negedge clk); #1;
    rdy_rand  = rr;
    cur_plain = !pk && !upk;
    for (int k = 0; k < nv * ns; k++) begin
      logic [IDXW-1:0] s;
      logic [IDXW-1:0] d;
      s = IDXW'(idx_at(k, pk, nv, ns));
      d = IDXW'(idx_at(k, upk, nv, ns));
      exp_q.push_back({s, d, (k == nv * ns - 1)});
    end
    vl = VLW'(v); subvl_m1 = 2'(svm1); pack_en = pk; unpack_en = upk;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (nv > 0) check(out_valid == 1'b1, "R2 valid one cycle after start", int'(out_valid), 1);
    else        check(out_valid == 1'b0, "R9 zero length gives no beat", int'(out_valid), 0);
    if (poke_busy) begin
      repeat (3) begin @(negedge clk); #1; end
      check(out_valid == 1'b1, "R9 still busy before poke", int'(out_valid), 1);
      vl = VLW'(2); subvl_m1 = 2'd0; pack_en = 1'b0; unpack_en = 1'b1;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    wait_done();
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) begin @(negedge clk); #1; end
    check(out_valid == 1'b0, "R1 valid low after reset", int'(out_valid), 0);

    run_op(4, 1, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 R8 element-major both sides
    run_op(4, 1, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 R5 pack only
    run_op(3, 2, 1'b0, 1'b1, 1'b1, 1'b0);   // R5 unpack, SUBVL 3, stalls
    run_op(5, 3, 1'b1, 1'b1, 1'b1, 1'b0);   // R5 both enables
    run_op(1, 0, 1'b1, 1'b1, 1'b0, 1'b0);   // R6 R10 single beat
    run_op(7, 0, 1'b1, 1'b0, 1'b1, 1'b0);   // R10 SUBVL 1
    run_op(31, 3, 1'b1, 1'b0, 1'b1, 1'b0);  // R10 length clamped to MAX_VL
    run_op(0, 2, 1'b1, 1'b0, 1'b0, 1'b0);   // R9 zero length
    run_op(6, 1, 1'b1, 1'b0, 1'b1, 1'b1);   // R9 start while busy
    run_op(9, 2, 1'b0, 1'b0, 1'b1, 1'b0);   // R8 R7 long plain copy with stalls

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule